// File: doc/BRIEF.md
# Dual-Processor Doorbell Interrupt Unit

This block lets two processors ring each other through small interrupt doorbells. Every processor owns a four-bit status word. A write to that processor's set register turns bits on, and a write to its clear register turns bits off. Each status word drives its own level interrupt line, which is high while any bit of the word is on. A receiving processor reads its status word to see which doorbells are pending, then acknowledges them through the clear register.

The block answers a 4 KB window of 32-bit little-endian words on a simple request/response register bus. The host raises `req_valid` together with the address, direction and write data, and holds them steady until `rsp_ready` is seen. The block accepts a request on a rising edge where `req_valid` is high and `rsp_ready` is low. On the next cycle it pulses `rsp_ready` for exactly one cycle, with the read data and the error flag. The host has no way to hold back a response, so a response is never stalled. A request that is still presented during the `rsp_ready` cycle is not taken at that edge. Near the top of the window sits a fixed table of twelve identification bytes.

Top module: `doorbell_unit`

## Requirements
- R1: A request is accepted on a rising edge where `req_valid`=1 and `rsp_ready`=0. `rsp_ready` is then high for exactly the following cycle. A request held through the `rsp_ready` cycle is not accepted at that edge, and is accepted again at the edge after it.
- R2: A write to offset 0x04 (processor 0) or 0x14 (processor 1) ORs `req_wdata[3:0]` into that processor's status word, and leaves the other processor's word unchanged.
- R3: A write to offset 0x08 (processor 0) or 0x18 (processor 1) clears every status bit of that processor for which `req_wdata[3:0]` holds a 1.
- R4: Bits 31:4 of the write data have no effect on any status word.
- R5: A read of offset 0x00 (processor 0) or 0x10 (processor 1) returns that status word in bits 3:0, with bits 31:4 zero and no error.
- R6: `irq[n]` is high exactly when status word n is nonzero. It changes one cycle after the `rsp_ready` cycle of the write that changed the word.
- R7: Reads of offsets 0xFD0, 0xFD4, …, 0xFFC (twelve words) return 0x04, 0x00, 0x00, 0x00, 0x56, 0xB8, 0x0B, 0x00, 0x0D, 0xF0, 0x05, 0xB1, in rising address order, with no error.
- R8: A read of a set or clear register returns 0 and raises `rsp_err`. A write to a status or ID register raises `rsp_err` and changes nothing.
- R9: Any other offset counts as unmapped, and so does any offset whose bits 1:0 are nonzero. A read of an unmapped offset returns 0, and a write to one changes nothing. Both raise `rsp_err`.
- R10: While `rst` is high, both status words clear, and `irq` and `rsp_ready` are low.
- R11: `rsp_err` is only ever high in a cycle where `rsp_ready` is high. It stays low for legal accesses, and write responses carry `rsp_rdata`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present; held until `rsp_ready` |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte offset inside the 4 KB window |
| req_wdata | input | 32 | Write data |
| rsp_ready | output | 1 | One-cycle response strobe |
| rsp_rdata | output | 32 | Read data, valid with `rsp_ready` |
| rsp_err | output | 1 | Illegal access, valid with `rsp_ready` |
| irq | output | 2 | Doorbell interrupt per processor, level |

## Verification
The bench builds the block with its default values: two processors, four doorbell bits, a 12-bit window and twelve ID words. At that size every one of the 4096 byte offsets can be read and written, and every pair of 4-bit set and clear patterns can be applied on both processors. Each offset is sorted into status, set, clear, ID or unmapped by arithmetic in the bench, so each class of illegal access is reached at every address it covers.

// File: rtl/doorbell_pkg.sv
package doorbell_pkg;

  localparam int unsigned IDX_W = 4;

  typedef enum logic [2:0] {
    RG_NONE = 3'd0,
    RG_STAT = 3'd1,
    RG_SET  = 3'd2,
    RG_CLR  = 3'd3,
    RG_ID   = 3'd4
  } reg_kind_e;

  typedef struct packed {
    reg_kind_e        kind;
    logic [IDX_W-1:0] idx;
  } dec_t;

  // Identification bytes, in rising address order
  function automatic logic [7:0] id_byte(input logic [IDX_W-1:0] idx);
    logic [7:0] b;
    case (idx)
      4'd0:    b = 8'h04;
      4'd4:    b = 8'h56;
      4'd5:    b = 8'hB8;
      4'd6:    b = 8'h0B;
      4'd8:    b = 8'h0D;
      4'd9:    b = 8'hF0;
      4'd10:   b = 8'h05;
      4'd11:   b = 8'hB1;
      default: b = 8'h00;
    endcase
    return b;
  endfunction

endpackage

// File: rtl/doorbell_decode.sv
module doorbell_decode
  import doorbell_pkg::*;
#(
  parameter int unsigned ADDR_W     = 12,
  parameter int unsigned NUM_CPU    = 2,
  parameter int unsigned CPU_STRIDE = 16,
  parameter int unsigned ID_BASE    = 32'hFD0,
  parameter int unsigned ID_COUNT   = 12
) (
  input  logic [ADDR_W-1:0] addr,
  output dec_t              dec
);
  localparam int unsigned STAT_OFF = 0;
  localparam int unsigned SET_OFF  = 4;
  localparam int unsigned CLR_OFF  = 8;
  localparam int unsigned ID_END   = ID_BASE + 4 * ID_COUNT;

  logic [31:0] a_full;
  assign a_full = 32'(addr);

  always_comb begin
    dec.kind = RG_NONE;
    dec.idx  = '0;
    if (addr[1:0] == 2'b00) begin
      if (a_full >= ID_BASE && a_full < ID_END) begin
        dec.kind = RG_ID;
        dec.idx  = IDX_W'((a_full - ID_BASE) >> 2);
      end
      for (int unsigned c = 0; c < NUM_CPU; c++) begin
        if (a_full == c * CPU_STRIDE + STAT_OFF) begin
          dec.kind = RG_STAT;
          dec.idx  = IDX_W'(c);
        end else if (a_full == c * CPU_STRIDE + SET_OFF) begin
          dec.kind = RG_SET;
          dec.idx  = IDX_W'(c);
        end else if (a_full == c * CPU_STRIDE + CLR_OFF) begin
          dec.kind = RG_CLR;
          dec.idx  = IDX_W'(c);
        end
      end
    end
  end
endmodule

// File: rtl/doorbell_cell.sv
module doorbell_cell #(
  parameter int unsigned DB_BITS = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               set_en,
  input  logic               clr_en,
  input  logic [DB_BITS-1:0] wbits,
  output logic [DB_BITS-1:0] status,
  output logic               irq
);
  always_ff @(posedge clk) begin
    if (rst) begin
      status <= '0;
    end else if (set_en) begin
      status <= status | wbits;
    end else if (clr_en) begin
      status <= status & ~wbits;
    end
  end

  // Registered level: follows the status word one cycle later
  always_ff @(posedge clk) begin
    if (rst) begin
      irq <= 1'b0;
    end else begin
      irq <= |status;
    end
  end
endmodule

// File: rtl/doorbell_idrom.sv
module doorbell_idrom
  import doorbell_pkg::*;
#(
  parameter int unsigned ID_COUNT = 12,
  parameter int unsigned DATA_W   = 32
) (
  input  logic [IDX_W-1:0]  idx,
  output logic [DATA_W-1:0] value
);
  assign value = (32'(idx) < ID_COUNT) ? DATA_W'(id_byte(idx)) : '0;
endmodule

// File: rtl/doorbell_unit.sv
module doorbell_unit
  import doorbell_pkg::*;
#(
  parameter int unsigned ADDR_W     = 12,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned NUM_CPU    = 2,
  parameter int unsigned DB_BITS    = 4,
  parameter int unsigned CPU_STRIDE = 16,
  parameter int unsigned ID_BASE    = 32'hFD0,
  parameter int unsigned ID_COUNT   = 12
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic               req_write,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [DATA_W-1:0]  req_wdata,
  output logic               rsp_ready,
  output logic [DATA_W-1:0]  rsp_rdata,
  output logic               rsp_err,
  output logic [NUM_CPU-1:0] irq
);
  dec_t               dec;
  logic               accept;
  logic [DATA_W-1:0]  id_value;
  logic [DATA_W-1:0]  rd_next;
  logic               err_next;
  logic [DB_BITS-1:0] wbits;
  logic [DB_BITS-1:0] stat_w [NUM_CPU];
  logic               unused_wdata_hi;

  assign accept          = req_valid && !rsp_ready;
  assign wbits           = req_wdata[DB_BITS-1:0];
  assign unused_wdata_hi = ^req_wdata[DATA_W-1:DB_BITS];

  doorbell_decode #(
    .ADDR_W    (ADDR_W),
    .NUM_CPU   (NUM_CPU),
    .CPU_STRIDE(CPU_STRIDE),
    .ID_BASE   (ID_BASE),
    .ID_COUNT  (ID_COUNT)
  ) u_dec (
    .addr(req_addr),
    .dec (dec)
  );

  doorbell_idrom #(
    .ID_COUNT(ID_COUNT),
    .DATA_W  (DATA_W)
  ) u_id (
    .idx  (dec.idx),
    .value(id_value)
  );

  for (genvar g = 0; g < NUM_CPU; g++) begin : g_cpu
    logic set_hit;
    logic clr_hit;
    assign set_hit = accept && req_write && dec.kind == RG_SET && dec.idx == IDX_W'(g);
    assign clr_hit = accept && req_write && dec.kind == RG_CLR && dec.idx == IDX_W'(g);

    doorbell_cell #(.DB_BITS(DB_BITS)) u_cell (
      .clk   (clk),
      .rst   (rst),
      .set_en(set_hit),
      .clr_en(clr_hit),
      .wbits (wbits),
      .status(stat_w[g]),
      .irq   (irq[g])
    );
  end

  // Response data and legality for the request being accepted
  always_comb begin
    rd_next  = '0;
    err_next = 1'b0;
    case (dec.kind)
      RG_STAT: begin
        if (req_write) begin
          err_next = 1'b1;
        end else begin
          for (int unsigned c = 0; c < NUM_CPU; c++) begin
            if (dec.idx == IDX_W'(c)) rd_next = DATA_W'(stat_w[c]);
          end
        end
      end
      RG_SET, RG_CLR: err_next = !req_write;
      RG_ID: begin
        if (req_write) err_next = 1'b1;
        else           rd_next  = id_value;
      end
      default: err_next = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_ready <= 1'b0;
      rsp_rdata <= '0;
      rsp_err   <= 1'b0;
    end else begin
      rsp_ready <= accept;
      rsp_rdata <= accept ? rd_next : '0;
      rsp_err   <= accept && err_next;
    end
  end
endmodule

// File: rtl/doorbell_chk.sv
module doorbell_chk #(
  parameter int unsigned ADDR_W     = 12,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned NUM_CPU    = 2,
  parameter int unsigned CPU_STRIDE = 16
) (
  input logic               clk,
  input logic               rst,
  input logic               req_valid,
  input logic               req_write,
  input logic [ADDR_W-1:0]  req_addr,
  input logic               rsp_ready,
  input logic [DATA_W-1:0]  rsp_rdata,
  input logic               rsp_err,
  input logic [NUM_CPU-1:0] irq
);
  logic              wr_q;
  logic [ADDR_W-1:0] addr_q;
  logic              wo_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_q   <= 1'b0;
      addr_q <= '0;
    end else if (req_valid && !rsp_ready) begin
      wr_q   <= req_write;
      addr_q <= req_addr;
    end
  end

  assign wo_q = (32'(addr_q) < NUM_CPU * CPU_STRIDE) &&
                (32'(addr_q) % CPU_STRIDE == 4 || 32'(addr_q) % CPU_STRIDE == 8);

  // R1
  ready_follows_accept_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !rsp_ready) |=> rsp_ready);

  // R1
  ready_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_ready |=> !rsp_ready);

  // R11
  err_only_with_ready_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_err |-> rsp_ready);

  // R8
  err_data_zero_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_err |-> rsp_rdata == '0);

  // R8
  write_only_read_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_ready && !wr_q && wo_q) |-> rsp_err);

  // R6
  irq_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rsp_ready && wr_q) |-> $stable(irq));

  // R10
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (irq == '0 && !rsp_ready));
endmodule

bind doorbell_unit doorbell_chk #(
  .ADDR_W    (ADDR_W),
  .DATA_W    (DATA_W),
  .NUM_CPU   (NUM_CPU),
  .CPU_STRIDE(CPU_STRIDE)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .req_valid(req_valid),
  .req_write(req_write),
  .req_addr (req_addr),
  .rsp_ready(rsp_ready),
  .rsp_rdata(rsp_rdata),
  .rsp_err  (rsp_err),
  .irq      (irq)
);

// File: tb/tb_doorbell_unit.sv
module tb_doorbell_unit;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 190000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [11:0] req_addr  = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_ready;
  logic [31:0] rsp_rdata;
  logic        rsp_err;
  logic [1:0]  irq;

  int n_chk = 0;
  int n_bad = 0;
  logic [3:0] model [2];
  logic [7:0] id_exp [12] = '{8'h04, 8'h00, 8'h00, 8'h00, 8'h56, 8'hB8,
                              8'h0B, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};

  always #(CLK_PERIOD / 2) clk = ~clk;

  doorbell_unit dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_ready(rsp_ready),
    .rsp_rdata(rsp_rdata), .rsp_err(rsp_err), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One transfer; returns after the cycle in which irq has settled
  task automatic xact(input logic wr, input logic [11:0] a, input logic [31:0] d,
                      output logic [31:0] rd, output logic er);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(posedge clk);
    @(negedge clk);
    check("R1 ready", 32'(rsp_ready), 32'd1);
    rd = rsp_rdata; er = rsp_err;
    req_valid = 1'b0;
    @(negedge clk);
    check("R1 pulse", 32'(rsp_ready), 32'd0);
    check("R11 idle err", 32'(rsp_err), 32'd0);
  endtask

  function automatic logic [32:0] exp_read(input int a);
    if (a % 4 != 0) return {1'b1, 32'h0};
    if (a == 0)    return {1'b0, 28'h0, model[0]};
    if (a == 16)   return {1'b0, 28'h0, model[1]};
    if (a == 4 || a == 8 || a == 20 || a == 24) return {1'b1, 32'h0};
    if (a >= 32'hFD0) return {1'b0, 24'h0, id_exp[(a - 32'hFD0) / 4]};
    return {1'b1, 32'h0};
  endfunction

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    logic        er;
    logic [32:0] ex;
    model[0] = '0; model[1] = '0;

    repeat (3) @(negedge clk);
    check("R10 ready in reset", 32'(rsp_ready), 32'd0);
    check("R10 irq in reset", 32'(irq), 32'd0);
    rst = 1'b0;
    xact(1'b0, 12'h000, '0, rd, er);
    check("R10 stat0 after reset", rd, 32'd0);
    xact(1'b0, 12'h010, '0, rd, er);
    check("R10 stat1 after reset", rd, 32'd0);

    // Every set/clear pattern pair on both processors, junk in the upper bits
    for (int c = 0; c < 2; c++) begin
      for (int s = 0; s < 16; s++) begin
        for (int k = 0; k < 16; k++) begin
          logic [11:0] base;
          base = 12'(c * 16);
          xact(1'b1, base + 12'h8, 32'hFFFF_FFFF, rd, er);
          check("R3 clear all", 32'(irq[c]), 32'd0);
          xact(1'b1, base + 12'h4, {28'h5A5A_C3E, 4'(s)}, rd, er);
          check("R2 set err", 32'(er), 32'd0);
          check("R6 irq after set", 32'(irq[c]), 32'(s != 0));
          check("R2 other cpu untouched", 32'(irq[1-c]), 32'd0);
          xact(1'b0, base, '0, rd, er);
          check("R2 R5 status after set", rd, 32'(s));
          check("R5 status err", 32'(er), 32'd0);
          xact(1'b1, base + 12'h8, {28'h9E37_79B, 4'(k)}, rd, er);
          check("R11 write rdata", rd, 32'd0);
          check("R6 irq after clear", 32'(irq[c]), 32'((s & ~k & 15) != 0));
          xact(1'b0, base, '0, rd, er);
          check("R3 R4 status after clear", rd, 32'(s & ~k & 15));
        end
      end
      xact(1'b1, 12'(c * 16 + 8), 32'hF, rd, er);
    end

    // Read sweep over the whole window
    xact(1'b1, 12'h004, 32'hFFFF_FFFA, rd, er); model[0] = 4'hA;
    xact(1'b1, 12'h014, 32'h0000_0005, rd, er); model[1] = 4'h5;
    for (int a = 0; a < 4096; a++) begin
      xact(1'b0, 12'(a), '0, rd, er);
      ex = exp_read(a);
      if (a >= 32'hFD0 && a % 4 == 0) check("R7 id value", rd, ex[31:0]);
      else if (ex[32]) check("R8 R9 illegal read data", rd, 32'd0);
      else check("R5 status read", rd, ex[31:0]);
      check("R8 R9 R11 read err", 32'(er), 32'(ex[32]));
    end

    // Write sweep: every non-writable offset raises err and changes nothing
    for (int a = 0; a < 4096; a++) begin
      if (a == 4 || a == 8 || a == 20 || a == 24) continue;
      xact(1'b1, 12'(a), 32'hFFFF_FFFF, rd, er);
      check("R8 R9 write err", 32'(er), 32'd1);
      check("R8 R9 irq unchanged", 32'(irq), 32'd3);
    end
    xact(1'b0, 12'h000, '0, rd, er);
    check("R8 R9 stat0 unchanged", rd, 32'hA);
    xact(1'b0, 12'h010, '0, rd, er);
    check("R8 R9 stat1 unchanged", rd, 32'h5);

    // Request held through the ready cycle is taken only at the edge after
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 12'hFE4;
    @(negedge clk);
    check("R1 first ready", 32'(rsp_ready), 32'd1);
    check("R1 first data", rsp_rdata, 32'hB8);
    @(negedge clk);
    check("R1 held not taken", 32'(rsp_ready), 32'd0);
    @(negedge clk);
    check("R1 held taken again", 32'(rsp_ready), 32'd1);
    req_valid = 1'b0;
    @(negedge clk);
    check("R1 back to idle", 32'(rsp_ready), 32'd0);

    // Reset in the middle of pending doorbells
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R10 irq cleared by reset", 32'(irq), 32'd0);
    rst = 1'b0;
    xact(1'b0, 12'h000, '0, rd, er);
    check("R10 stat0 cleared", rd, 32'd0);

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule